// File: doc/BRIEF.md
# Multi-Phase Clock Recovery Selector

This block recovers a bit clock and retimed data from an alternate-mark-inversion line. It runs on a fast clock. A reference slot tick splits each bit period into thirteen equal phase slots. The two line leads reach the block as two unipolar pulse inputs, each already sliced outside the block. A pulse on either lead is a mark.

Whenever a mark begins, the block picks the phase slot that lies six slots after that leading edge. From then on it samples once per bit period at that slot. It emits a one-cycle recovered clock enable together with the mark state of each rail for the bit period just ended. Between marks, during runs of zeros, the selected phase free-runs. Two tick sources can drive the slot counter: an external reference tick or a local oscillator tick. A select input chooses between them.

Top module: `mphase_clk_rec`

## Requirements
- R1: While `rst_n` is low, `rclk_en`, `rx_pos` and `rx_neg` are 0 and `phase_sel` is 6. This holds at once, without waiting for a clock edge.
- R2: Each recovered bit reports on `rx_pos` whether the positive lead carried a mark during that bit period, and on `rx_neg` whether the negative lead did. If both leads carry a mark, both rails read 1.
- R3: With the slot tick active every cycle, a mark whose leading edge is sampled at clock edge k yields a `rclk_en` pulse after clock edge k+6. That pulse is visible during the cycle that follows. The phase selected is `phase_sel` = (slot at the edge + 6) mod 13.
- R4: A leading edge that arrives at a different slot of the bit period moves the sampling point to 6 slots after the new edge. The bit period in which the move happens still gives exactly one `rclk_en` pulse.
- R5: A bit period with no mark yields a `rclk_en` pulse at the last selected phase, 13 slots after the previous one, with both rails 0.
- R6: A pulse held high across a bit boundary has no new leading edge. The phase stays where it is, and every bit period the pulse covers reads as a mark.
- R7: `ref_sel` = 0 takes `ext_tick` as the slot tick and `ref_sel` = 1 takes `osc_tick`. On a cycle without the selected tick, slots do not advance, pulses are not sampled, `phase_sel` holds and `rclk_en` stays 0.
- R8: `rclk_en` is never high in two consecutive cycles. `rx_pos` and `rx_neg` change only in a cycle where `rclk_en` is high.
- R9: `phase_sel` always lies in 0 to 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_sel | input | 1 | Slot tick source: 0 external, 1 oscillator |
| ext_tick | input | 1 | External reference slot tick |
| osc_tick | input | 1 | Local oscillator slot tick |
| pos_pulse | input | 1 | Sliced positive-lead pulse |
| neg_pulse | input | 1 | Sliced negative-lead pulse |
| rclk_en | output | 1 | One-cycle recovered bit clock enable |
| rx_pos | output | 1 | Recovered positive-rail bit |
| rx_neg | output | 1 | Recovered negative-rail bit |
| phase_sel | output | 4 | Currently selected sampling slot |

## Verification
The assertions check several properties on every cycle. The recovered clock enable stays one cycle wide, and the rail outputs hold between strobes. A cycle with no selected tick never produces a strobe and never moves the phase, and the phase index stays in range.

Other behaviours show up only in the bench's scenarios, because each depends on where a pulse sits within the bit period:
- the exact strobe position relative to a leading edge,
- the move of the phase when the edge shifts, with one strobe in the transition bit,
- the per-rail data values,
- a held pulse that spans two bits,
- zero runs that keep the old phase.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

endpackage

// File: rtl/mcr_rst_sync.sv
module mcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/mcr_edge_det.sv
module mcr_edge_det
  import mcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_en,
  input  logic  pos_in,
  input  logic  neg_in,
  output rail_t marks,
  output logic  lead_edge
);

  logic mark_now;
  logic mark_q;
  logic mark_d;

  always_comb begin
    marks.pos = pos_in;
    marks.neg = neg_in;
    mark_now  = pos_in | neg_in;
    lead_edge = slot_en & mark_now & ~mark_q;
    mark_d    = slot_en ? mark_now : mark_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mark_q <= 1'b0;
    else        mark_q <= mark_d;
  end

endmodule

// File: rtl/mcr_phase_sel.sv
module mcr_phase_sel #(
  parameter int PHASES     = 13,
  parameter int SAMPLE_OFS = 6,
  localparam int SLOT_W    = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_en,
  input  logic              lead_edge,
  output logic              fire,
  output logic [SLOT_W-1:0] phase_q
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PHASES - 1);
  localparam logic [SLOT_W:0]   OFS_W     = (SLOT_W + 1)'(SAMPLE_OFS);
  localparam logic [SLOT_W:0]   PH_W      = (SLOT_W + 1)'(PHASES);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SLOT_W-1:0] phase_d;
  logic [SLOT_W:0]   target_sum;
  logic [SLOT_W-1:0] target;

  always_comb begin
    target_sum = {1'b0, slot_q} + OFS_W;
    if (target_sum >= PH_W) target = SLOT_W'(target_sum - PH_W);
    else                    target = target_sum[SLOT_W-1:0];

    if (slot_en) slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    else         slot_d = slot_q;

    phase_d = lead_edge ? target : phase_q;
    fire    = slot_en & (slot_q == phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      phase_q <= SLOT_W'(SAMPLE_OFS);
    end else begin
      slot_q  <= slot_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/mcr_bit_latch.sv
module mcr_bit_latch
  import mcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_en,
  input  logic  fire,
  input  rail_t marks,
  output logic  strobe_q,
  output rail_t rx_q
);

  rail_t seen_q, seen_d;
  rail_t rx_d;
  logic  strobe_d;

  always_comb begin
    if (fire)         seen_d = marks;
    else if (slot_en) seen_d = seen_q | marks;
    else              seen_d = seen_q;
    rx_d     = fire ? seen_q : rx_q;
    strobe_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= '0;
      rx_q     <= '0;
      strobe_q <= 1'b0;
    end else begin
      seen_q   <= seen_d;
      rx_q     <= rx_d;
      strobe_q <= strobe_d;
    end
  end

endmodule

// File: rtl/mphase_clk_rec.sv
module mphase_clk_rec
  import mcr_pkg::*;
#(
  parameter int PHASES     = 13,
  parameter int SAMPLE_OFS = 6,
  localparam int SLOT_W    = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_sel,
  input  logic              ext_tick,
  input  logic              osc_tick,
  input  logic              pos_pulse,
  input  logic              neg_pulse,
  output logic              rclk_en,
  output logic              rx_pos,
  output logic              rx_neg,
  output logic [SLOT_W-1:0] phase_sel
);

  logic  rst_core_n;
  logic  slot_en;
  logic  lead_edge;
  logic  fire;
  rail_t marks;
  rail_t rx_q;

  always_comb slot_en = ref_sel ? osc_tick : ext_tick;

  mcr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mcr_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .slot_en   (slot_en),
    .pos_in    (pos_pulse),
    .neg_in    (neg_pulse),
    .marks     (marks),
    .lead_edge (lead_edge)
  );

  mcr_phase_sel #(
    .PHASES     (PHASES),
    .SAMPLE_OFS (SAMPLE_OFS)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .slot_en   (slot_en),
    .lead_edge (lead_edge),
    .fire      (fire),
    .phase_q   (phase_sel)
  );

  mcr_bit_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .slot_en  (slot_en),
    .fire     (fire),
    .marks    (marks),
    .strobe_q (rclk_en),
    .rx_q     (rx_q)
  );

  always_comb begin
    rx_pos = rx_q.pos;
    rx_neg = rx_q.neg;
  end

endmodule

// File: rtl/mphase_clk_rec_chk.sv
module mphase_clk_rec_chk #(
  parameter int PHASES  = 13,
  parameter int SLOT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_sel,
  input logic              ext_tick,
  input logic              osc_tick,
  input logic              rclk_en,
  input logic              rx_pos,
  input logic              rx_neg,
  input logic [SLOT_W-1:0] phase_sel
);

  logic sel_tick;
  always_comb sel_tick = ref_sel ? osc_tick : ext_tick;

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_en |=> !rclk_en);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rclk_en |-> ($stable(rx_pos) && $stable(rx_neg)));

  // R7
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> !rclk_en);

  // R7
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> $stable(phase_sel));

  // R9
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase_sel) < PHASES);

endmodule

bind mphase_clk_rec mphase_clk_rec_chk #(
  .PHASES (PHASES),
  .SLOT_W (SLOT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_sel   (ref_sel),
  .ext_tick  (ext_tick),
  .osc_tick  (osc_tick),
  .rclk_en   (rclk_en),
  .rx_pos    (rx_pos),
  .rx_neg    (rx_neg),
  .phase_sel (phase_sel)
);

// File: tb/mphase_clk_rec_tb.sv
module mphase_clk_rec_tb;

  logic       clk;
  logic       rst_n;
  logic       ref_sel;
  logic       ext_tick;
  logic       osc_tick;
  logic       pos_pulse;
  logic       neg_pulse;
  logic       rclk_en;
  logic       rx_pos;
  logic       rx_neg;
  logic [3:0] phase_sel;

  int n_chk;
  int n_fail;
  bit finished;

  mphase_clk_rec u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_sel   (ref_sel),
    .ext_tick  (ext_tick),
    .osc_tick  (osc_tick),
    .pos_pulse (pos_pulse),
    .neg_pulse (neg_pulse),
    .rclk_en   (rclk_en),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .phase_sel (phase_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: [7:6] rail (bit6 positive lead, bit7 negative lead),
  // [5:2] slot offset of the pulse in the bit, [1] expected rx_pos, [0] expected rx_neg
  localparam logic [7:0] VEC [16] = '{
    {2'd1, 4'd0, 2'b10}, {2'd2, 4'd0, 2'b01}, {2'd0, 4'd0, 2'b00}, {2'd1, 4'd0, 2'b10},
    {2'd1, 4'd0, 2'b10}, {2'd3, 4'd0, 2'b11}, {2'd2, 4'd4, 2'b01}, {2'd0, 4'd4, 2'b00},
    {2'd1, 4'd4, 2'b10}, {2'd2, 4'd2, 2'b01}, {2'd0, 4'd2, 2'b00}, {2'd1, 4'd5, 2'b10},
    {2'd2, 4'd0, 2'b01}, {2'd0, 4'd0, 2'b00}, {2'd3, 4'd0, 2'b11}, {2'd1, 4'd0, 2'b10}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_bit(input logic [1:0] rail, input int off, input logic ep,
                         input logic en, input bit chk, input string ttag);
    int   strobes = 0;
    int   where   = -1;
    bit   hold_ok = 1'b1;
    logic dp = 1'b0, dn = 1'b0, lp = 1'b0, ln = 1'b0;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      if (i == 0) begin
        lp = rx_pos;
        ln = rx_neg;
      end
      if (rclk_en) begin
        strobes++;
        where = i;
        dp = rx_pos; dn = rx_neg;
        lp = rx_pos; ln = rx_neg;
      end else if (rx_pos !== lp || rx_neg !== ln) begin
        hold_ok = 1'b0;
      end
      pos_pulse = rail[0] && (i >= off) && (i < off + 6);
      neg_pulse = rail[1] && (i >= off) && (i < off + 6);
    end
    pos_pulse = 1'b0;
    neg_pulse = 1'b0;
    if (chk) begin
      check(strobes == 1 && where == off + 7, ttag, "strobe slot", where, off + 7);
      check({dp, dn} == {ep, en}, "R2", "rails", int'({dp, dn}), int'({ep, en}));
      check(hold_ok, "R8", "rx hold between strobes", int'(hold_ok), 1);
      check(phase_sel < 4'd13, "R9", "phase range", int'(phase_sel), 12);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int   prev_off;
    int   cnt;
    logic [3:0] ph;
    bit   found;
    string ttag;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; ref_sel = 1'b0; ext_tick = 1'b1; osc_tick = 1'b0;
    pos_pulse = 1'b0; neg_pulse = 1'b0;

    repeat (4) @(negedge clk);
    // R1 reset state
    check(!rclk_en && !rx_pos && !rx_neg, "R1", "outputs in reset",
          int'({rclk_en, rx_pos, rx_neg}), 0);
    check(phase_sel == 4'd6, "R1", "phase in reset", int'(phase_sel), 6);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_bit(2'd1, 0, 1'b1, 1'b0, 1'b0, "");
    prev_off = 0;
    for (int v = 0; v < 16; v++) begin
      int off;
      off = int'(VEC[v][5:2]);
      if (off != prev_off)       ttag = "R4";
      else if (VEC[v][7:6] == 0) ttag = "R5";
      else                       ttag = "R3";
      run_bit(VEC[v][7:6], off, VEC[v][1], VEC[v][0], 1'b1, ttag);
      prev_off = off;
    end

    // R5 long run of zeros keeps the last phase
    for (int z = 0; z < 12; z++) run_bit(2'd0, 0, 1'b0, 1'b0, 1'b1, "R5");

    // R6 pulse held across a bit boundary
    ph = phase_sel;
    cnt = 0;
    found = 1'b1;
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      if (rclk_en) begin
        cnt++;
        if (!((i == 7 || i == 20) && rx_pos && !rx_neg)) found = 1'b0;
      end
      pos_pulse = (i < 19);
    end
    pos_pulse = 1'b0;
    check(cnt == 2 && found, "R6", "held pulse strobes", cnt, 2);
    check(phase_sel == ph, "R6", "phase unchanged", int'(phase_sel), int'(ph));
    run_bit(2'd0, 0, 1'b0, 1'b0, 1'b1, "R6");

    // R7 oscillator tick selected, external tick idle
    @(negedge clk);
    ref_sel = 1'b1; osc_tick = 1'b1; ext_tick = 1'b0;
    run_bit(2'd1, 1, 1'b1, 1'b0, 1'b1, "R7");
    ph = phase_sel;
    ref_sel = 1'b0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rclk_en) cnt++;
      pos_pulse = (i >= 5 && i < 11);
    end
    pos_pulse = 1'b0;
    check(cnt == 0, "R7", "no strobe without selected tick", cnt, 0);
    check(phase_sel == ph, "R7", "phase frozen", int'(phase_sel), int'(ph));
    ext_tick = 1'b1;
    found = 1'b0;
    for (int i = 0; i < 14 && !found; i++) begin
      @(negedge clk);
      if (rclk_en) begin
        found = 1'b1;
        check(!rx_pos && !rx_neg, "R7", "ungated pulse ignored",
              int'({rx_pos, rx_neg}), 0);
      end
    end
    check(found, "R7", "strobe resumes", int'(found), 1);

    // R1 reset in mid operation
    run_bit(2'd2, 0, 1'b0, 1'b1, 1'b0, "");
    @(negedge clk);
    pos_pulse = 1'b1;
    rst_n = 1'b0;
    #1;
    check(!rclk_en && !rx_pos && !rx_neg && phase_sel == 4'd6, "R1",
          "async reset mid run", int'({rclk_en, rx_pos, rx_neg, phase_sel}), 6);
    pos_pulse = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule